// File: doc/BRIEF.md
# Configuration Address/Data Port Decoder

This block watches a simple host I/O bus and turns one pair of port locations into configuration-space requests. One location is a 32-bit address latch. Software writes a target bus, device, function and dword register index into it, together with an enable bit. The other location is a four-byte data window. A read or write there becomes one configuration request for the dword named by the latch. The low two bits of the port address choose the first byte lane, and the access width sets how many lanes are used.

Accesses that fall on neither location leave through pass-through strobes, so the rest of the I/O space behaves as before. The configuration side is a plain request interface. It carries the target fields, the byte enables, the write data lined up to their lanes, and a write flag. The responder returns read data and an acknowledge in the same cycle. The host bus sees a ready flag that follows that acknowledge. The block itself holds only the 32-bit latch; everything else is combinational from the current access.

Top module: `cfg1_port_decoder`

## Requirements
- R1: After a synchronous reset the address latch holds zero, so its enable bit (bit 31) is off and a dword read of the latch port returns 0.
- R2: A dword write (size code 2) to the latch port stores the write data with bits 30:24 and bits 1:0 forced to zero. A later dword read of that port returns the stored value. Both accesses are claimed and complete with ready in the same cycle.
- R3: Byte (code 0), word (code 1) and code-3 accesses to the latch port, and any access outside the latch port and the four data-window ports, are not claimed. They raise the matching pass-through strobe, return read data 0 and leave the latch unchanged.
- R4: While the enable bit is set, a read or write anywhere in the data window raises a configuration request. Its fields are: bus = latch bits 23:16, device = bits 15:11 (0 to 31), function = bits 10:8, dword register index = bits 7:2. The write flag is set exactly for writes.
- R5: The byte enables equal a lane mask of 1 lane (code 0), 2 lanes (code 1) or 4 lanes (codes 2 and 3), shifted up by the port offset (port address bits 1:0). Lanes past lane 3 are dropped.
- R6: The configuration write data is the host write data shifted up by eight times the port offset.
- R7: For an enabled data-window read, the returned data is the responder data shifted down by eight times the port offset, with bytes beyond the access width set to zero. Ready for an enabled data-window access follows the responder acknowledge.
- R8: While the enable bit is clear, a data-window access raises no configuration request. A read returns all ones, a write is dropped, and ready is given in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | Host I/O port address |
| io_size | input | 2 | Access width: 0 byte, 1 word, 2 or 3 dword |
| io_wdata | input | 32 | Host write data, right-aligned |
| io_wr | input | 1 | Host write strobe |
| io_rd | input | 1 | Host read strobe |
| io_rdata | output | 32 | Read data for claimed reads, right-aligned |
| io_claim | output | 1 | Access decoded by this block |
| io_ready | output | 1 | Claimed access completes this cycle |
| pt_wr | output | 1 | Pass-through write strobe |
| pt_rd | output | 1 | Pass-through read strobe |
| cfg_req | output | 1 | Configuration request |
| cfg_we | output | 1 | Request is a write |
| cfg_bus | output | 8 | Target bus number |
| cfg_dev | output | 5 | Target device number |
| cfg_func | output | 3 | Target function number |
| cfg_regno | output | 6 | Dword register index |
| cfg_be | output | 4 | Byte enables |
| cfg_wdata | output | 32 | Lane-aligned write data |
| cfg_ack | input | 1 | Responder acknowledge |
| cfg_rdata | input | 32 | Responder read data, dword-aligned |

## Verification
The bench builds the block with its default port parameters: the latch at 0xCF8 and the data window at 0xCFC through 0xCFF. With those values the window reaches all four lane offsets, including a word at offset 3 whose upper lane falls off the dword. The latch port sits right beside window ports and plain ports such as 0xCFB and 0xD00, so decode edges on both sides can be tested. A sweep over all 32 device numbers with changing bus and function values covers each latch field bit.

// File: rtl/cfg1_pkg.sv
`timescale 1ns/1ps
package cfg1_pkg;

    localparam int LANES   = 4;
    localparam int DATA_W  = 8 * LANES;
    localparam int BUS_W   = 8;
    localparam int DEV_W   = 5;
    localparam int FN_W    = 3;
    localparam int REGNO_W = 6;
    localparam int RSVD_W  = DATA_W - 1 - BUS_W - DEV_W - FN_W - REGNO_W - 2;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_WIDE  = 2'd3
    } io_size_e;

    typedef enum logic [1:0] {
        HIT_NONE  = 2'd0,
        HIT_LATCH = 2'd1,
        HIT_DATA  = 2'd2
    } hit_e;

    typedef struct packed {
        logic               en;
        logic [RSVD_W-1:0]  rsvd;
        logic [BUS_W-1:0]   bus;
        logic [DEV_W-1:0]   dev;
        logic [FN_W-1:0]    fn;
        logic [REGNO_W-1:0] regno;
        logic [1:0]         align;
    } cfg_addr_t;

    function automatic logic [LANES-1:0] width_mask(io_size_e sz);
        case (sz)
            SZ_BYTE: return LANES'(4'b0001);
            SZ_WORD: return LANES'(4'b0011);
            default: return '1;
        endcase
    endfunction

    function automatic logic [LANES-1:0] lane_enables(io_size_e sz, logic [1:0] off);
        logic [2*LANES-1:0] wide;
        wide = {{LANES{1'b0}}, width_mask(sz)} << off;
        return wide[LANES-1:0];
    endfunction

    function automatic logic [DATA_W-1:0] byte_mask(io_size_e sz);
        logic [LANES-1:0]  m;
        logic [DATA_W-1:0] r;
        m = width_mask(sz);
        for (int i = 0; i < LANES; i++) begin
            r[8*i +: 8] = {8{m[i]}};
        end
        return r;
    endfunction

    function automatic cfg_addr_t latch_filter(logic [DATA_W-1:0] raw);
        cfg_addr_t a;
        a       = cfg_addr_t'(raw);
        a.rsvd  = '0;
        a.align = '0;
        return a;
    endfunction

endpackage

// File: rtl/cfg1_port_match.sv
`timescale 1ns/1ps
module cfg1_port_match
    import cfg1_pkg::*;
#(
    parameter logic [15:0] ADDR_PORT = 16'h0CF8,
    parameter logic [15:0] DATA_PORT = 16'h0CFC
) (
    input  logic [15:0] io_addr,
    input  logic [1:0]  io_size,
    input  logic        io_rd,
    input  logic        io_wr,
    output hit_e        hit,
    output logic [1:0]  offset,
    output logic        pt_rd,
    output logic        pt_wr
);
    localparam int WIN_W = 16 - 2;
    localparam logic [WIN_W-1:0] WIN_BASE = DATA_PORT[15:2];

    logic strobe;
    logic latch_match;
    logic data_match;

    always_comb begin
        strobe      = io_rd | io_wr;
        latch_match = (io_addr == ADDR_PORT) && (io_size_e'(io_size) == SZ_DWORD);
        data_match  = (io_addr[15:2] == WIN_BASE);
        offset      = io_addr[1:0];
        if (!strobe)          hit = HIT_NONE;
        else if (latch_match) hit = HIT_LATCH;
        else if (data_match)  hit = HIT_DATA;
        else                  hit = HIT_NONE;
        pt_rd = io_rd && (hit == HIT_NONE);
        pt_wr = io_wr && (hit == HIT_NONE);
    end
endmodule

// File: rtl/cfg1_addr_latch.sv
`timescale 1ns/1ps
module cfg1_addr_latch
    import cfg1_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] wdata,
    output cfg_addr_t         q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= latch_filter(wdata);
        end
    end
endmodule

// File: rtl/cfg1_lane_steer.sv
`timescale 1ns/1ps
module cfg1_lane_steer
    import cfg1_pkg::*;
(
    input  logic [1:0]        io_size,
    input  logic [1:0]        offset,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [DATA_W-1:0] resp_rdata,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] lane_wdata,
    output logic [DATA_W-1:0] host_rdata
);
    logic [4:0] shamt;

    always_comb begin
        shamt      = {offset, 3'b000};
        be         = lane_enables(io_size_e'(io_size), offset);
        lane_wdata = host_wdata << shamt;
        host_rdata = (resp_rdata >> shamt) & byte_mask(io_size_e'(io_size));
    end
endmodule

// File: rtl/cfg1_port_decoder.sv
`timescale 1ns/1ps
module cfg1_port_decoder
    import cfg1_pkg::*;
#(
    parameter logic [15:0] ADDR_PORT = 16'h0CF8,
    parameter logic [15:0] DATA_PORT = 16'h0CFC
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] io_addr,
    input  logic [1:0]  io_size,
    input  logic [31:0] io_wdata,
    input  logic        io_wr,
    input  logic        io_rd,
    output logic [31:0] io_rdata,
    output logic        io_claim,
    output logic        io_ready,
    output logic        pt_wr,
    output logic        pt_rd,
    output logic        cfg_req,
    output logic        cfg_we,
    output logic [7:0]  cfg_bus,
    output logic [4:0]  cfg_dev,
    output logic [2:0]  cfg_func,
    output logic [5:0]  cfg_regno,
    output logic [3:0]  cfg_be,
    output logic [31:0] cfg_wdata,
    input  logic        cfg_ack,
    input  logic [31:0] cfg_rdata
);
    hit_e              hit;
    logic [1:0]        offset;
    cfg_addr_t         addr_q;
    logic              latch_load;
    logic              data_go;
    logic [DATA_W-1:0] steer_rdata;

    cfg1_port_match #(
        .ADDR_PORT (ADDR_PORT),
        .DATA_PORT (DATA_PORT)
    ) u_match (
        .io_addr (io_addr),
        .io_size (io_size),
        .io_rd   (io_rd),
        .io_wr   (io_wr),
        .hit     (hit),
        .offset  (offset),
        .pt_rd   (pt_rd),
        .pt_wr   (pt_wr)
    );

    assign latch_load = (hit == HIT_LATCH) && io_wr;

    cfg1_addr_latch u_latch (
        .clk   (clk),
        .rst   (rst),
        .load  (latch_load),
        .wdata (io_wdata),
        .q     (addr_q)
    );

    cfg1_lane_steer u_steer (
        .io_size    (io_size),
        .offset     (offset),
        .host_wdata (io_wdata),
        .resp_rdata (cfg_rdata),
        .be         (cfg_be),
        .lane_wdata (cfg_wdata),
        .host_rdata (steer_rdata)
    );

    always_comb begin
        data_go   = (hit == HIT_DATA) && addr_q.en;
        cfg_req   = data_go;
        cfg_we    = data_go && io_wr;
        cfg_bus   = addr_q.bus;
        cfg_dev   = addr_q.dev;
        cfg_func  = addr_q.fn;
        cfg_regno = addr_q.regno;
        io_claim  = (hit != HIT_NONE);

        unique case (hit)
            HIT_LATCH: io_ready = 1'b1;
            HIT_DATA:  io_ready = addr_q.en ? cfg_ack : 1'b1;
            default:   io_ready = 1'b0;
        endcase

        io_rdata = '0;
        if (io_rd) begin
            if (hit == HIT_LATCH) begin
                io_rdata = addr_q;
            end else if (hit == HIT_DATA) begin
                io_rdata = addr_q.en ? steer_rdata : '1;
            end
        end
    end
endmodule

// File: rtl/cfg1_port_decoder_chk.sv
`timescale 1ns/1ps
module cfg1_port_decoder_chk
    import cfg1_pkg::*;
#(
    parameter logic [15:0] ADDR_PORT = 16'h0CF8,
    parameter logic [15:0] DATA_PORT = 16'h0CFC
) (
    input logic        clk,
    input logic        rst,
    input logic [15:0] io_addr,
    input logic [1:0]  io_size,
    input logic [31:0] io_wdata,
    input logic        io_wr,
    input logic        io_rd,
    input logic        io_claim,
    input logic        pt_wr,
    input logic        pt_rd,
    input logic        cfg_req,
    input logic [3:0]  cfg_be,
    input cfg_addr_t   addr_q
);
    logic latch_wr;
    assign latch_wr = io_wr && (io_addr == ADDR_PORT) && (io_size == 2'd2);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (addr_q == '0));

    p_latch_load_r2: assert property (@(posedge clk) disable iff (rst)
        latch_wr |=> (addr_q == ($past(io_wdata) & 32'h80FF_FFFC)));

    p_latch_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !latch_wr |=> $stable(addr_q));

    p_claim_excl_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({io_claim, pt_rd | pt_wr}));

    p_req_window_r4: assert property (@(posedge clk) disable iff (rst)
        cfg_req |-> ((io_addr[15:2] == DATA_PORT[15:2]) && (io_rd || io_wr)));

    p_byte_one_lane_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg_req && io_size == 2'd0) |-> ($countones(cfg_be) == 1));

    p_req_needs_en_r8: assert property (@(posedge clk) disable iff (rst)
        cfg_req |-> addr_q.en);
endmodule

bind cfg1_port_decoder cfg1_port_decoder_chk #(
    .ADDR_PORT (ADDR_PORT),
    .DATA_PORT (DATA_PORT)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .io_addr  (io_addr),
    .io_size  (io_size),
    .io_wdata (io_wdata),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .io_claim (io_claim),
    .pt_wr    (pt_wr),
    .pt_rd    (pt_rd),
    .cfg_req  (cfg_req),
    .cfg_be   (cfg_be),
    .addr_q   (addr_q)
);

// File: tb/test_cfg1_port_decoder.sv
`timescale 1ns/1ps
module test_cfg1_port_decoder;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] io_addr;
    logic [1:0]  io_size;
    logic [31:0] io_wdata;
    logic        io_wr, io_rd;
    logic [31:0] io_rdata;
    logic        io_claim, io_ready, pt_wr, pt_rd;
    logic        cfg_req, cfg_we;
    logic [7:0]  cfg_bus;
    logic [4:0]  cfg_dev;
    logic [2:0]  cfg_func;
    logic [5:0]  cfg_regno;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata;
    logic        cfg_ack;
    logic [31:0] cfg_rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    logic [31:0] ref_latch;

    always #2.5 clk = ~clk;

    cfg1_port_decoder i_cfg1_port_decoder (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_size(io_size),
        .io_wdata(io_wdata), .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
        .io_claim(io_claim), .io_ready(io_ready), .pt_wr(pt_wr), .pt_rd(pt_rd),
        .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_bus(cfg_bus), .cfg_dev(cfg_dev),
        .cfg_func(cfg_func), .cfg_regno(cfg_regno), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_ack(cfg_ack), .cfg_rdata(cfg_rdata)
    );

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Reference model: computes every output from the current inputs and
    // the modelled latch value, then compares. Called mid-cycle.
    task automatic compare_all(string tag);
        int  off, nbytes, lanes, shifted;
        bit  strobe, latch_hit, data_hit, en;
        logic [31:0] exp_rd, bmask;
        strobe    = io_rd || io_wr;
        latch_hit = strobe && io_addr == 16'h0CF8 && io_size == 2'd2;
        data_hit  = strobe && !latch_hit && io_addr >= 16'h0CFC && io_addr <= 16'h0CFF;
        en        = ref_latch[31];
        off       = int'(io_addr[1:0]);
        nbytes    = (io_size == 2'd0) ? 1 : (io_size == 2'd1) ? 2 : 4;
        lanes     = ((1 << nbytes) - 1) << off;
        bmask     = (nbytes == 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * nbytes)) - 1);

        check(tag, "claim", {31'b0, io_claim}, {31'b0, latch_hit || data_hit});
        check(tag, "pt_rd", {31'b0, pt_rd}, {31'b0, io_rd && !(latch_hit || data_hit)});
        check(tag, "pt_wr", {31'b0, pt_wr}, {31'b0, io_wr && !(latch_hit || data_hit)});
        check(tag, "cfg_req", {31'b0, cfg_req}, {31'b0, data_hit && en});

        if (data_hit && en) begin
            check(tag, "cfg_we", {31'b0, cfg_we}, {31'b0, io_wr});
            check(tag, "bus", {24'b0, cfg_bus}, (ref_latch >> 16) & 32'hFF);
            check(tag, "dev", {27'b0, cfg_dev}, (ref_latch >> 11) & 32'h1F);
            check(tag, "func", {29'b0, cfg_func}, (ref_latch >> 8) & 32'h7);
            check(tag, "regno", {26'b0, cfg_regno}, (ref_latch >> 2) & 32'h3F);
            check(tag, "be", {28'b0, cfg_be}, lanes & 32'hF);
            if (io_wr) check(tag, "cfg_wdata", cfg_wdata, io_wdata << (8 * off));
        end

        if (latch_hit)              check(tag, "ready", {31'b0, io_ready}, 32'd1);
        else if (data_hit && !en)   check(tag, "ready", {31'b0, io_ready}, 32'd1);
        else if (data_hit)          check(tag, "ready", {31'b0, io_ready}, {31'b0, cfg_ack});
        else                        check(tag, "ready", {31'b0, io_ready}, 32'd0);

        exp_rd = 32'h0;
        if (io_rd && latch_hit)          exp_rd = ref_latch;
        else if (io_rd && data_hit && !en) exp_rd = 32'hFFFF_FFFF;
        else if (io_rd && data_hit)      exp_rd = (cfg_rdata >> (8 * off)) & bmask;
        check(tag, "io_rdata", io_rdata, exp_rd);
        shifted = 0;
    endtask

    task automatic access(string tag, logic [15:0] a, logic [1:0] sz, bit wr,
                          logic [31:0] wd, bit ack, logic [31:0] crd);
        @(negedge clk);
        io_addr = a; io_size = sz; io_wr = wr; io_rd = !wr; io_wdata = wd;
        cfg_ack = ack; cfg_rdata = crd;
        #1;
        compare_all(tag);
        @(posedge clk);
        if (wr && a == 16'h0CF8 && sz == 2'd2)
            ref_latch = wd & 32'h80FF_FFFC;
        #0.5;
        @(negedge clk);
        io_wr = 0; io_rd = 0; cfg_ack = 0;
        #1;
        compare_all(tag);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst = 1; io_addr = 0; io_size = 0; io_wdata = 0; io_wr = 0; io_rd = 0;
        cfg_ack = 0; cfg_rdata = 0; ref_latch = 0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 0;

        // R1: latch clear after reset
        access("R1", 16'h0CF8, 2'd2, 0, 0, 0, 0);

        // R8: disabled window
        access("R8", 16'h0CFC, 2'd2, 0, 0, 1, 32'h1234_5678);
        access("R8", 16'h0CFE, 2'd0, 1, 32'hAB, 1, 0);
        access("R8", 16'h0CFD, 2'd1, 0, 0, 0, 0);

        // R2: store with reserved and alignment bits cleared
        access("R2", 16'h0CF8, 2'd2, 1, 32'hFFFF_FFFF, 0, 0);
        access("R2", 16'h0CF8, 2'd2, 0, 0, 0, 0);

        // R3: narrow latch accesses and foreign ports pass through
        access("R3", 16'h0CF8, 2'd0, 1, 32'h0, 0, 0);
        access("R3", 16'h0CF8, 2'd1, 1, 32'h0, 0, 0);
        access("R3", 16'h0CF8, 2'd3, 1, 32'h0, 0, 0);
        access("R3", 16'h0CF8, 2'd1, 0, 0, 0, 0);
        access("R3", 16'h0CF8, 2'd2, 0, 0, 0, 0);
        access("R3", 16'h0CFB, 2'd0, 0, 0, 1, 32'hDEAD_BEEF);
        access("R3", 16'h0D00, 2'd2, 1, 32'h5, 1, 0);
        access("R3", 16'h0080, 2'd0, 0, 0, 0, 0);

        // R4..R7: enabled window, bus 0x12 dev 0x15 fn 3 reg 0x11
        access("R4", 16'h0CF8, 2'd2, 1, 32'h8012_AB44, 0, 0);
        access("R7", 16'h0CFC, 2'd2, 0, 0, 1, 32'h1122_3344);
        access("R7", 16'h0CFD, 2'd0, 0, 0, 1, 32'h1122_3344);
        access("R7", 16'h0CFE, 2'd1, 0, 0, 1, 32'h1122_3344);
        access("R7", 16'h0CFF, 2'd1, 0, 0, 1, 32'h1122_3344);
        access("R7", 16'h0CFD, 2'd2, 0, 0, 1, 32'hA1B2_C3D4);
        access("R7", 16'h0CFC, 2'd2, 0, 0, 0, 32'h1122_3344);
        for (int o = 0; o < 4; o++) begin
            for (int s = 0; s < 4; s++) begin
                access("R5", 16'h0CFC + 16'(o), 2'(s), 1, 32'hCAFE_F00D, 1, 0);
                access("R6", 16'h0CFC + 16'(o), 2'(s), 1, 32'h0102_0304 + 32'(o * 16 + s), 1, 0);
            end
        end

        // R4: sweep every device number with varying bus and function
        for (int d = 0; d < 32; d++) begin
            access("R4", 16'h0CF8, 2'd2, 1,
                   32'h8000_0000 | 32'((d * 7) & 255) << 16 | 32'(d) << 11 | 32'(d & 7) << 8 | 32'(d * 4 + 1), 0, 0);
            access("R4", 16'h0CFC + 16'(d & 3), 2'(d & 3), (d & 1) == 1, 32'(d), 1, 32'(d) * 32'h0101_0101);
        end

        // R8: disable again with other fields kept
        access("R8", 16'h0CF8, 2'd2, 1, 32'h0012_AB44, 0, 0);
        access("R8", 16'h0CFF, 2'd0, 0, 0, 1, 32'h1122_3344);
        access("R8", 16'h0CFC, 2'd2, 1, 32'h9, 1, 0);

        finish_run();
    end
endmodule